// File: doc/BRIEF.md
# Phase-Staggered Multichannel PWM Generator

This block produces pulse-width modulation for twelve motor-driver channels from a single shared step counter with 32 steps per period. Each channel has its own duty value. A stagger mode can rotate each channel's high window by a fixed number of steps, so that the channels switch on different steps. This spreads the supply current spikes of the drivers across the period instead of letting them all land together. Staggering moves the high window in time and leaves the duty unchanged.

The step counter advances on an external tick enable. Duty and stagger mode are taken into shadow registers only on the tick that wraps the counter from 31 to 0, so every period is generated whole from one set of values. On each tick the twelve channel bits of the new step are also sent out serially, with a shift clock and a latch pulse, for chains of external output shift registers.

Top module: `stagger_pwm`

## Requirements
- R1: A synchronous active-high reset returns the step counter to 0 and clears all shadow values. After reset every `pwmOut` bit, `serData`, `serClk` and `serLatch` are low.
- R2: The step counter advances by one on each clock edge where `tickEn` is high and wraps from 31 to 0. It holds its value when `tickEn` is low.
- R3: With stagger mode 0 (none) or 3 (treated as none), channel k is high exactly when the step counter is less than its shadow duty. All channels therefore rise together at step 0.
- R4: With stagger mode 1 (full), channel k uses offset k. It is high when (counter − k) mod 32 is less than its shadow duty.
- R5: With stagger mode 2 (pair), channels 2m and 2m+1 share offset m. Each channel is high when (counter − m) mod 32 is less than its shadow duty.
- R6: In every complete period, each channel is high for exactly as many steps as its shadow duty value. A duty of 0 keeps the channel low and a duty of 31 gives 31 high steps.
- R7: `dutyIn` (channel k in bits [5k+4:5k]) and `modeIn` are sampled only on the tick that wraps the counter from 31 to 0. A change at any other time has no effect on `pwmOut` until that tick.
- R8: The clock cycle after a tick begins a serial frame of 12 bits, sent channel 11 first. Each bit is held for one cycle with `serClk` low and then for one cycle with `serClk` high. A single-cycle `serLatch` follows the 12th high phase, and `serLatch` is never high in the same cycle as `serClk`. Ticks must be at least 26 cycles apart.
- R9: The bits of each serial frame equal the `pwmOut` vector of the step the tick entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Advances the step counter by one |
| modeIn | input | 2 | Stagger mode: 0 none, 1 full, 2 pair, 3 none |
| dutyIn | input | 60 | Twelve 5-bit duty values, channel k in bits [5k+4:5k] |
| pwmOut | output | 12 | One PWM bit per channel |
| serData | output | 1 | Serial channel bit, channel 11 first |
| serClk | output | 1 | Shift clock for external registers |
| serLatch | output | 1 | One-cycle latch pulse after the 12th bit |

## Verification
The reference model tracks the step counter, the shadow values and the offsets of each mode on its own, and compares every channel on every clock. Duty and mode are changed mid-period on purpose, so a design that sampled them outside the wrap would show a torn period that the model does not predict. The duties include 0, 31 and values whose staggered windows wrap past step 31. A wrong modulo in the rotation would therefore lose or add high steps, which the per-period count of high steps catches. Every serial frame is checked against the expected vector of its step. A frame sent in reversed order, with a missing bit or with a misplaced latch fails that comparison.

// File: rtl/stagger_pwm_pkg.sv
package stagger_pwm_pkg;

  typedef enum logic [1:0] {
    STAG_NONE = 2'd0,
    STAG_FULL = 2'd1,
    STAG_PAIR = 2'd2,
    STAG_ALT  = 2'd3
  } stagMode_e;

  typedef struct packed {
    logic loadShadow;
    logic capture;
    logic shift;
  } pwmStrobe_t;

endpackage

// File: rtl/stagger_pwm_ctl.sv
module stagger_pwm_ctl
  import stagger_pwm_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strobe,
  output logic             serClk,
  output logic             serLatch
);

  localparam int SER_LAST = 2 * NUM_CH + 2;
  localparam int SER_W    = $clog2(SER_LAST + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [SER_W-1:0] serCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      serCnt <= '0;
    end else begin
      if (tickEn) begin
        cnt    <= cnt + 1'b1;
        serCnt <= SER_W'(1);
      end else if (serCnt != '0) begin
        serCnt <= (serCnt == SER_W'(SER_LAST)) ? '0 : serCnt + 1'b1;
      end
    end
  end

  // bit j occupies steps 2+2j (clock low) and 3+2j (clock high)
  assign serClk   = serCnt[0] && (serCnt >= SER_W'(3)) && (serCnt < SER_W'(SER_LAST));
  assign serLatch = (serCnt == SER_W'(SER_LAST));

  assign strobe.loadShadow = tickEn && (cnt == CNT_TOP);
  assign strobe.capture    = (serCnt == SER_W'(1));
  assign strobe.shift      = serClk;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(cnt)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> ((cnt - $past(cnt)) == CNT_W'(1))); // R2
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    serLatch |=> !serLatch); // R8
  AST_LATCH_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    !(serLatch && serClk)); // R8

endmodule

// File: rtl/stagger_pwm_dp.sv
module stagger_pwm_dp
  import stagger_pwm_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CNT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pwmStrobe_t              strobe,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [1:0]              modeIn,
  input  logic [NUM_CH*CNT_W-1:0] dutyIn,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic                    serData
);

  logic [NUM_CH-1:0][CNT_W-1:0] dutyShadow;
  stagMode_e                    modeShadow;
  logic [NUM_CH-1:0]            shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyShadow <= '0;
      modeShadow <= STAG_NONE;
      shiftReg   <= '0;
    end else begin
      if (strobe.loadShadow) begin
        dutyShadow <= dutyIn;
        modeShadow <= stagMode_e'(modeIn);
      end
      if (strobe.capture) begin
        shiftReg <= pwmOut;
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[NUM_CH-2:0], 1'b0};
      end
    end
  end

  assign serData = shiftReg[NUM_CH-1];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    localparam logic [CNT_W-1:0] OFF_FULL = CNT_W'(k);
    localparam logic [CNT_W-1:0] OFF_PAIR = CNT_W'(k / 2);
    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] relStep;

    always_comb begin
      case (modeShadow)
        STAG_FULL: offset = OFF_FULL;
        STAG_PAIR: offset = OFF_PAIR;
        default:   offset = '0;
      endcase
    end

    assign relStep   = cnt - offset;
    assign pwmOut[k] = (relStep < dutyShadow[k]);

    AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
      (dutyShadow[k] == '0) |-> !pwmOut[k]); // R6
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadShadow |=> ($stable(dutyShadow) && $stable(modeShadow))); // R7
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (pwmOut == '0 && !serData)); // R1

endmodule

// File: rtl/stagger_pwm.sv
module stagger_pwm
  import stagger_pwm_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CNT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tickEn,
  input  logic [1:0]              modeIn,
  input  logic [NUM_CH*CNT_W-1:0] dutyIn,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic                    serData,
  output logic                    serClk,
  output logic                    serLatch
);

  logic [CNT_W-1:0] cnt;
  pwmStrobe_t       strobe;

  stagger_pwm_ctl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cnt(cnt), .strobe(strobe),
    .serClk(serClk), .serLatch(serLatch)
  );

  stagger_pwm_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cnt(cnt), .modeIn(modeIn),
    .dutyIn(dutyIn), .pwmOut(pwmOut), .serData(serData)
  );

endmodule

// File: tb/test_stagger_pwm.sv
`timescale 1ns/1ps
module test_stagger_pwm;

  localparam int NCH = 12;
  localparam int DW  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              tickEn = 1'b0;
  logic [1:0]        modeIn = 2'd0;
  logic [NCH*DW-1:0] dutyIn = '0;
  logic [NCH-1:0]    pwmOut;
  logic              serData, serClk, serLatch;

  stagger_pwm i_stagger_pwm (
    .clk(clk), .rst(rst), .tickEn(tickEn), .modeIn(modeIn), .dutyIn(dutyIn),
    .pwmOut(pwmOut), .serData(serData), .serClk(serClk), .serLatch(serLatch)
  );

  int nChecks = 0;
  int nFails  = 0;

  // behavioural reference state
  int mCnt = 0;
  int mMode = 0;
  int mDuty[NCH];
  bit started = 0;
  bit ticked = 0;
  bit midChange = 0;
  logic [NCH-1:0] snap;
  bit snapValid = 0;
  bit serBits[$];
  int hiCnt[NCH];
  int perDuty[NCH];
  bit perValid = 0;

  function automatic bit expBit(int k);
    int off;
    off = (mMode == 1) ? k : (mMode == 2) ? k / 2 : 0;
    return (((mCnt - off + 32) % 32) < mDuty[k]);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mCnt = 0; mMode = 0; ticked = 0; snapValid = 0; perValid = 0; midChange = 0;
      for (int k = 0; k < NCH; k++) mDuty[k] = 0;
      serBits.delete();
    end else if (tickEn) begin
      if (mCnt == 31) begin
        for (int k = 0; k < NCH; k++) mDuty[k] = int'(dutyIn[k*DW +: DW]);
        mMode = int'(modeIn);
        midChange = 0;
      end
      mCnt = (mCnt + 1) % 32;
      ticked = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      string tag;
      tag = midChange ? "R7" : (mMode == 1) ? "R2,R4" : (mMode == 2) ? "R2,R5" : "R2,R3";
      for (int k = 0; k < NCH; k++) begin
        nChecks++;
        if (pwmOut[k] !== expBit(k)) begin
          nFails++;
          $display("FAIL %s ch%0d step %0d mode %0d: pwm actual %b expected %b",
                   tag, k, mCnt, mMode, pwmOut[k], expBit(k));
        end
      end
      if (ticked) begin
        ticked = 0;
        for (int k = 0; k < NCH; k++) snap[k] = expBit(k);
        snapValid = 1;
        serBits.delete();
        if (mCnt == 0) begin
          if (perValid) begin
            for (int k = 0; k < NCH; k++) begin
              nChecks++;
              if (hiCnt[k] != perDuty[k]) begin
                nFails++;
                $display("FAIL R6 ch%0d high steps actual %0d expected %0d",
                         k, hiCnt[k], perDuty[k]);
              end
            end
          end
          for (int k = 0; k < NCH; k++) begin perDuty[k] = mDuty[k]; hiCnt[k] = 0; end
          perValid = 1;
        end
        if (perValid)
          for (int k = 0; k < NCH; k++) hiCnt[k] += int'(pwmOut[k]);
      end
      if (serClk) serBits.push_back(serData);
      if (serLatch) begin
        logic [NCH-1:0] got;
        got = '0;
        nChecks++;
        if (serBits.size() != NCH || !snapValid) begin
          nFails++;
          $display("FAIL R8 frame bits actual %0d expected %0d", serBits.size(), NCH);
        end else begin
          for (int i = 0; i < NCH; i++) got[NCH-1-i] = serBits[i];
          nChecks++;
          if (got !== snap) begin
            nFails++;
            $display("FAIL R9 frame actual %h expected %h", got, snap);
          end
        end
        serBits.delete();
        snapValid = 0;
      end
    end
  end

  task automatic doTicks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tickEn = 1'b1;
      @(posedge clk); #1 tickEn = 1'b0;
      repeat (gap - 2) @(posedge clk);
    end
  endtask

  task automatic checkReset();
    @(negedge clk);
    nChecks++;
    if (pwmOut !== '0 || serData !== 1'b0 || serClk !== 1'b0 || serLatch !== 1'b0) begin
      nFails++;
      $display("FAIL R1 after reset actual pwm %h ser %b%b%b expected all zero",
               pwmOut, serData, serClk, serLatch);
    end
  endtask

  task automatic setDuty(int seed);
    for (int k = 0; k < NCH; k++) dutyIn[k*DW +: DW] = DW'((k * seed + 3 * seed + 5) % 32);
    dutyIn[0 +: DW] = '0;
    dutyIn[(NCH-1)*DW +: DW] = 5'd31;
    dutyIn[5*DW +: DW] = DW'(seed % 32);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    checkReset(); // R1
    // R3: no stagger, several duty patterns
    setDuty(7);  modeIn = 2'd0;
    doTicks(64, 32);
    setDuty(13);
    doTicks(40, 27);
    // R7: mode and duty change in the middle of a period
    @(posedge clk); #1 midChange = 1; modeIn = 2'd1; setDuty(11);
    doTicks(70, 30);
    // R5: pair stagger
    @(posedge clk); #1 midChange = 1; modeIn = 2'd2; setDuty(9);
    doTicks(70, 33);
    // R3: reserved mode acts as none
    @(posedge clk); #1 midChange = 1; modeIn = 2'd3; setDuty(5);
    doTicks(70, 28);
    // R4: full stagger with a second pattern
    @(posedge clk); #1 midChange = 1; modeIn = 2'd1; setDuty(19);
    doTicks(45, 40);
    // R1: reset in the middle of a running period
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    checkReset();
    modeIn = 2'd2; setDuty(3);
    doTicks(70, 32);
    repeat (40) @(posedge clk);
    finishRun();
  end

endmodule